// File: doc/BRIEF.md
# Zero-Sum ROM Checksum Verifier

This block confirms at power-up that the program memory is intact. It owns up to `NUM_CHIPS` read-only memory sockets. Each socket holds `CHIP_BYTES` bytes behind a synchronous read port. The block reads every byte of each populated socket and keeps a wrap-around 8-bit sum.

The image is built so that every `SEG_BYTES` segment of every chip sums to zero. A spare byte in each segment holds the balancing value. The block checks the sum at each segment boundary and then clears it. A chip passes only when all of its segments come to zero.

Sockets are visited in ascending index order, and sockets marked empty are skipped. A chip is read only after the one before it has passed. The first bad segment stops the run. The block then reports the failing chip and the failing segment. A pulse on `start` begins a run, and `done` with `pass` gives the result.

Top module: `rom_zero_sum_checker`

## Requirements
- R1: During a run, `chip_sel` is one-hot, or zero when no read is in flight. For one chip, `rd_addr` steps through 0 to `CHIP_BYTES-1` one address per cycle, with no gaps and no repeats.
- R2: A socket whose bit in `chip_present` is 0 is never selected. Populated sockets are read in ascending index order.
- R3: Bytes are added modulo 256. The sum is tested at every 512-byte segment boundary and cleared there. A segment with a non-zero sum fails the chip, even when the whole chip sums to zero.
- R4: The next chip starts only after the last segment of the current chip has been checked. One cycle with `chip_sel` at zero separates two chips, so each passing chip takes `CHIP_BYTES+1` cycles.
- R5: On a failing segment, `done`=1 and `pass`=0 are set on the clock edge that consumes the segment's last byte. On that edge, `fail_chip` takes the socket index and `fail_seg` takes the segment number (byte address divided by 512). `chip_sel` is zero from that cycle on, and no later chip is read.
- R6: When every populated chip passes, `done`=1 and `pass`=1. If no socket is populated, this happens on the same edge that samples `start`.
- R7: Inverting any single bit of any byte in a populated chip makes the run fail. This includes the first byte and the balancing byte itself.
- R8: After reset, `done`=0, `pass`=0 and `chip_sel`=0. The result holds until the next `start`, and that `start` clears `done` whenever a chip is to be read.
- R9: Read data is taken one cycle after its address. A byte addressed in cycle t is added on the edge that ends cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is idle or done |
| chip_present | input | NUM_CHIPS | One bit per populated socket, latched at start |
| rd_data | input | 8 | Byte returned one cycle after its address |
| rd_addr | output | clog2(CHIP_BYTES) | Byte address within the selected chip |
| chip_sel | output | NUM_CHIPS | One-hot socket select, valid with rd_addr |
| done | output | 1 | Run finished |
| pass | output | 1 | All populated chips verified |
| fail_chip | output | clog2(NUM_CHIPS) | Index of the failing socket |
| fail_seg | output | clog2(CHIP_BYTES/512) | Segment of the failing chip |

## Verification
Call the edge that samples `start` E0. Address k of the j-th chip read is issued in the cycle after edge (j-1)(CHIP_BYTES+1)+k. Its byte is consumed two edges after that.

So a full pass of n chips sets `done` n(CHIP_BYTES+1) edges after E0. A failure whose segment ends at byte k sets `done` k+2 edges after that chip began. With no socket populated, `done` is set at E0 itself.

Each scenario counts edges from E0 and samples outputs one time step after each edge. It compares the edge count at which `done` rises against these formulas. It also records which sockets were ever selected, to check skipping and the early stop.

// File: rtl/rom_zero_sum_checker.sv
module rom_zero_sum_checker #(
  parameter int NUM_CHIPS  = 6,
  parameter int CHIP_BYTES = 2048,
  parameter int SEG_BYTES  = 512,
  localparam int ADDR_W  = $clog2(CHIP_BYTES),
  localparam int SEG_W   = $clog2(SEG_BYTES),
  localparam int SEGS    = CHIP_BYTES / SEG_BYTES,
  localparam int SEGI_W  = (SEGS > 1) ? $clog2(SEGS) : 1,
  localparam int CHIP_W  = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NUM_CHIPS-1:0] chip_present,
  input  logic [7:0]           rd_data,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [NUM_CHIPS-1:0] chip_sel,
  output logic                 done,
  output logic                 pass,
  output logic [CHIP_W-1:0]    fail_chip,
  output logic [SEGI_W-1:0]    fail_seg
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(CHIP_BYTES - 1);

  state_t               state_q;
  logic [CHIP_W-1:0]    chip_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [7:0]           acc_q;
  logic [NUM_CHIPS-1:0] mask_q;
  logic                 pend_q, pend_last_q;
  logic [SEGI_W-1:0]    pend_seg_q;
  logic                 done_q, pass_q;
  logic [CHIP_W-1:0]    fail_chip_q;
  logic [SEGI_W-1:0]    fail_seg_q;

  logic                 first_hit, next_hit;
  logic [CHIP_W-1:0]    first_idx, next_idx;
  logic [7:0]           sum;

  assign sum       = acc_q + rd_data;
  assign rd_addr   = addr_q;
  assign chip_sel  = (state_q == S_ISSUE) ? (NUM_CHIPS'(1) << chip_q) : '0;
  assign done      = done_q;
  assign pass      = pass_q;
  assign fail_chip = fail_chip_q;
  assign fail_seg  = fail_seg_q;

  always_comb begin
    first_hit = 1'b0;
    first_idx = '0;
    next_hit  = 1'b0;
    next_idx  = '0;
    for (int i = NUM_CHIPS - 1; i >= 0; i--) begin
      if (chip_present[i]) begin
        first_hit = 1'b1;
        first_idx = CHIP_W'(i);
      end
      if (mask_q[i] && (i > int'(chip_q))) begin
        next_hit = 1'b1;
        next_idx = CHIP_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      chip_q      <= '0;
      addr_q      <= '0;
      acc_q       <= '0;
      mask_q      <= '0;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
      pend_seg_q  <= '0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
      fail_chip_q <= '0;
      fail_seg_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: begin
          if (start) begin
            mask_q      <= chip_present;
            acc_q       <= '0;
            addr_q      <= '0;
            pend_q      <= 1'b0;
            fail_chip_q <= '0;
            fail_seg_q  <= '0;
            if (first_hit) begin
              chip_q  <= first_idx;
              state_q <= S_ISSUE;
              done_q  <= 1'b0;
              pass_q  <= 1'b0;
            end else begin
              state_q <= S_DONE;
              done_q  <= 1'b1;
              pass_q  <= 1'b1;
            end
          end
        end
        S_ISSUE: begin
          pend_q      <= 1'b1;
          pend_last_q <= &addr_q[SEG_W-1:0];
          pend_seg_q  <= SEGI_W'(addr_q >> SEG_W);
          addr_q      <= addr_q + 1'b1;
          if (addr_q == LAST_ADDR) state_q <= S_WAIT;
        end
        default: pend_q <= 1'b0;
      endcase

      if (pend_q) begin
        if (!pend_last_q) begin
          acc_q <= sum;
        end else begin
          acc_q <= '0;
          if (sum != 8'd0) begin
            state_q     <= S_DONE;
            pend_q      <= 1'b0;
            done_q      <= 1'b1;
            pass_q      <= 1'b0;
            fail_chip_q <= chip_q;
            fail_seg_q  <= pend_seg_q;
          end else if (state_q == S_WAIT) begin
            if (next_hit) begin
              chip_q  <= next_idx;
              addr_q  <= '0;
              state_q <= S_ISSUE;
            end else begin
              state_q <= S_DONE;
              done_q  <= 1'b1;
              pass_q  <= 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/rom_zero_sum_checker_chk.sv
module rom_zero_sum_checker_chk #(
  parameter int NUM_CHIPS  = 6,
  parameter int CHIP_BYTES = 2048,
  localparam int ADDR_W = $clog2(CHIP_BYTES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CHIPS-1:0] chip_present,
  input logic [NUM_CHIPS-1:0] chip_sel,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic                 done,
  input logic                 pass
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CHIP_BYTES - 1);

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chip_sel));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel != '0 && rd_addr != LAST) |=>
      (chip_sel == '0 || rd_addr == $past(rd_addr) + 1'b1));

  // R4
  chip_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel != '0 && rd_addr == LAST) |=> chip_sel == '0);

  // R2
  skip_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel & ~chip_present) == '0);

  // R5
  idle_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> chip_sel == '0);

  // R6
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

endmodule

bind rom_zero_sum_checker rom_zero_sum_checker_chk #(
  .NUM_CHIPS(NUM_CHIPS), .CHIP_BYTES(CHIP_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_present(chip_present),
  .chip_sel(chip_sel), .rd_addr(rd_addr), .done(done), .pass(pass)
);

// File: tb/rom_zero_sum_checker_tb.sv
`timescale 1ns/1ps
module rom_zero_sum_checker_tb;
  localparam int NC = 6;
  localparam int NB = 2048;
  localparam int SB = 512;
  localparam int AW = $clog2(NB);
  localparam int PER = NB + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NC-1:0] chip_present = '0;
  logic [7:0] rd_data = '0;
  logic [AW-1:0] rd_addr;
  logic [NC-1:0] chip_sel;
  logic done, pass;
  logic [2:0] fail_chip;
  logic [1:0] fail_seg;

  int n_cmp = 0, n_bad = 0;
  logic [NC-1:0] seen = '0;
  logic seen_clr = 1'b0;
  logic f_en [2];
  int f_chip [2];
  int f_addr [2];
  logic [7:0] f_xor [2];
  logic [7:0] f_add [2];

  always #5 clk = ~clk;

  rom_zero_sum_checker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_present(chip_present),
    .rd_data(rd_data), .rd_addr(rd_addr), .chip_sel(chip_sel),
    .done(done), .pass(pass), .fail_chip(fail_chip), .fail_seg(fail_seg));

  function automatic logic [7:0] base_byte(int c, int a);
    return 8'(a * 7 + c * 29 + (a >> 4) * 3 + 5);
  endfunction

  function automatic logic [7:0] rom_byte(int c, int a);
    logic [7:0] v, s;
    if (a % SB == SB - 1) begin
      s = '0;
      for (int j = a - (SB - 1); j < a; j++) s = s + base_byte(c, j);
      v = 8'(0) - s;
    end else v = base_byte(c, a);
    for (int k = 0; k < 2; k++)
      if (f_en[k] && f_chip[k] == c && f_addr[k] == a) v = (v ^ f_xor[k]) + f_add[k];
    return v;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < NC; i++)
      if (chip_sel[i]) rd_data <= rom_byte(i, int'(rd_addr));
    seen <= seen_clr ? '0 : (seen | chip_sel);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int k = 0; k < 2; k++) begin
      f_en[k] = 1'b0; f_chip[k] = 0; f_addr[k] = 0; f_xor[k] = '0; f_add[k] = '0;
    end
  endtask

  task automatic set_fault(input int k, input int c, input int a, input logic [7:0] x, input logic [7:0] d);
    f_en[k] = 1'b1; f_chip[k] = c; f_addr[k] = a; f_xor[k] = x; f_add[k] = d;
  endtask

  task automatic run(input string req, input logic [NC-1:0] mask, input bit exp_pass,
                     input int exp_chip, input int exp_seg, input int exp_lat,
                     input logic [NC-1:0] exp_seen);
    int lat;
    @(negedge clk);
    chip_present = mask; start = 1'b1; seen_clr = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; seen_clr = 1'b0; lat = 0;
    while (!done && lat < 20000) begin
      @(posedge clk); #1; lat++;
    end
    chk(done == 1'b1, req, "done", int'(done), 1);
    chk(lat == exp_lat, req, "edges to done", lat, exp_lat);
    chk(pass == exp_pass, req, "pass", int'(pass), int'(exp_pass));
    if (!exp_pass) begin
      chk(int'(fail_chip) == exp_chip, req, "fail_chip", int'(fail_chip), exp_chip);
      chk(int'(fail_seg) == exp_seg, req, "fail_seg", int'(fail_seg), exp_seg);
    end
    repeat (3) @(posedge clk);
    #1;
    chk(seen == exp_seen, req, "sockets selected", int'(seen), int'(exp_seen));
    chk(chip_sel == '0 && done, req, "idle and held after done", int'(chip_sel), 0);
  endtask

  // R8: reset values
  task automatic t_reset();
    @(negedge clk);
    chk(done == 1'b0, "R8", "done in reset", int'(done), 0);
    chk(pass == 1'b0, "R8", "pass in reset", int'(pass), 0);
    chk(chip_sel == '0, "R8", "chip_sel in reset", int'(chip_sel), 0);
  endtask

  // R1 R4 R6 R9: all sockets good
  task automatic t_all_good();
    clear_faults();
    run("R1/R4/R6/R9 all good", 6'h3F, 1'b1, 0, 0, 6 * PER, 6'h3F);
  endtask

  // R2: sparse population skips empty sockets
  task automatic t_sparse();
    clear_faults();
    run("R2 sparse", 6'b100010, 1'b1, 0, 0, 2 * PER, 6'b100010);
  endtask

  // R5 R7: single flipped bit mid-chip stops the run
  task automatic t_mid_flip();
    clear_faults();
    set_fault(0, 2, 1000, 8'h10, 8'h00);
    run("R5/R7 mid flip", 6'h3F, 1'b0, 2, 1, 2 * PER + 1023 + 2, 6'b000111);
  endtask

  // R7: flip in the balancing byte of the last segment
  task automatic t_last_flip();
    clear_faults();
    set_fault(0, 0, NB - 1, 8'h01, 8'h00);
    run("R7 balancing byte", 6'h3F, 1'b0, 0, 3, NB + 1, 6'b000001);
  endtask

  // R7: top bit of first byte
  task automatic t_first_flip();
    clear_faults();
    set_fault(0, 5, 0, 8'h80, 8'h00);
    run("R7 first byte", 6'b100000, 1'b0, 5, 0, SB + 1, 6'b100000);
  endtask

  // R2: fault in an empty socket has no effect
  task automatic t_fault_in_empty();
    clear_faults();
    set_fault(0, 3, 77, 8'hFF, 8'h00);
    run("R2 empty socket fault", 6'b110111, 1'b1, 0, 0, 5 * PER, 6'b110111);
  endtask

  // R3: errors that cancel over the chip still fail in segment 0
  task automatic t_seg_balance();
    clear_faults();
    set_fault(0, 4, 10, 8'h00, 8'h01);
    set_fault(1, 4, 600, 8'h00, 8'hFF);
    run("R3 per-segment", 6'b010000, 1'b0, 4, 0, SB + 1, 6'b010000);
  endtask

  // R6: nothing populated
  task automatic t_empty();
    clear_faults();
    run("R6 no sockets", 6'b000000, 1'b1, 0, 0, 0, 6'b000000);
  endtask

  // R8: restart after a failure clears the result
  task automatic t_restart();
    clear_faults();
    set_fault(0, 1, 5, 8'h02, 8'h00);
    run("R8 fail before restart", 6'b000010, 1'b0, 1, 0, SB + 1, 6'b000010);
    clear_faults();
    @(negedge clk);
    chip_present = 6'b000011; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(done == 1'b0, "R8", "done cleared by start", int'(done), 1'b0);
    chk(chip_sel == 6'b000001, "R8", "first socket selected", int'(chip_sel), 1);
    while (!done) begin @(posedge clk); #1; end
    chk(pass == 1'b1, "R8", "pass after restart", int'(pass), 1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_faults();
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    t_all_good();
    t_sparse();
    t_mid_flip();
    t_last_flip();
    t_first_flip();
    t_fault_in_empty();
    t_seg_balance();
    t_empty();
    t_restart();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule